// File: doc/BRIEF.md
# Vector Status Register Controller

This block owns the 64-bit status word of a vector unit. It executes five commands against that word: load the vector count from a signed immediate, load the interruption index from a signed immediate, set the mask mode, clear a chosen set of vector register pairs, and restore the whole word from a 64-bit operand. The two immediate loads saturate their operand to the range 0 to the section size. Each returns a condition code that tells which range the operand fell in.

A restore is checked before it takes effect. A bad operand leaves the word untouched and raises a one-cycle specification error. A good operand replaces the word. In problem state the changed flags are rebuilt from the in-use flags. Every pair whose in-use flag drops gets a clear request. The block drives those clear requests to an external register file and brings every field of the word out as a port.

Word layout: bit 63 holds the mask mode, bits 62:48 are reserved, bits 47:32 hold the vector count, bits 31:16 hold the interruption index, bits 15:8 hold the in-use flags and bits 7:0 hold the changed flags. In both flag bytes the most significant bit is pair 0 and the least significant bit is pair 14.

Top module: `vsr_ctrl`

## Requirements
- R1: On rst_ni low the word, the clear requests, the error flag, the condition code and its valid flag all go to zero at once, without waiting for a clock edge.
- R2: Op code 0 (load count) takes the signed value of operand bits 31:0. It stores that value clamped to 0..SECT in the count field. It returns cc 0 for zero, 1 for negative, 2 for a value above SECT and 3 otherwise, with cc_valid_o high for one cycle.
- R3: Op code 1 (load index) stores the operand clamped to 0..SECT in the index field. It returns cc 0 for zero, 1 for negative, 2 when the value is below the current count and 3 otherwise.
- R4: Op code 2 copies operand bit 0 into the mask mode, which appears on mask_mode_o and on bit 15 of mode_o.
- R5: Op code 3 zeroes the index field. Operand bit 7 selects pair 0 and each lower bit selects the next even pair, down to bit 0 for pair 14. For every selected pair the in-use flag is reset and the matching clr_req_o bit pulses for one cycle. Changed flags are kept.
- R6: Op code 4 (restore) with a valid operand loads the full word. mode_o shows word bits 63:48, vct_o bits 47:32, vix_o bits 31:16, inuse_o bits 15:8 and changed_o bits 7:0.
- R7: A restore is rejected if any of bits 62:48 is set, if the count field exceeds SECT, or if the index field is SECT or more. A rejected restore raises spec_err_o for one cycle, changes no field and requests no clear.
- R8: A valid restore with prob_state_i high stores operand bits 15:8 in both the in-use and the changed byte.
- R9: A valid restore pulses clr_req_o for every pair that was in use before it and is not in use in the restored word.
- R10: Results appear in the cycle after the command edge. Nothing changes while cmd_valid_i is low or for op codes 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command op code |
| cmd_opnd_i | input | 64 | Command operand |
| prob_state_i | input | 1 | Problem state qualifier for restore |
| vct_o | output | 16 | Vector count |
| vix_o | output | 16 | Interruption index |
| mask_mode_o | output | 1 | Mask mode |
| mode_o | output | 16 | Top 16 bits of the word |
| inuse_o | output | 8 | In-use flags, bit 7 is pair 0 |
| changed_o | output | 8 | Changed flags, bit 7 is pair 0 |
| clr_req_o | output | 8 | One-cycle clear requests, bit 7 is pair 0 |
| cc_o | output | 2 | Condition code of the last immediate load |
| cc_valid_o | output | 1 | cc_o was written by the last command |
| spec_err_o | output | 1 | Rejected restore, one cycle |

## Verification
A restore both rewrites the in-use byte and raises clear requests in the same cycle. The clear vector must be taken from the flags held before that edge, not from the new ones. The bench provokes this by restoring over a word with several pairs in use, some of which stay set and some drop. It then checks clr_req_o and inuse_o in the same sampled cycle. It also issues rejected restores over live in-use flags, to show that an error and a clear request never appear together.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  typedef enum logic [2:0] {
    OP_LDCNT = 3'd0,
    OP_LDIDX = 3'd1,
    OP_MASK  = 3'd2,
    OP_CLR   = 3'd3,
    OP_RST   = 3'd4
  } vsr_op_e;

  localparam int unsigned W_WORD   = 64;
  localparam int unsigned W_FLD    = 16;
  localparam int unsigned N_PAIR   = 8;
  localparam int unsigned B_MASK   = 63;
  localparam int unsigned B_RES_HI = 62;
  localparam int unsigned B_RES_LO = 48;
  localparam int unsigned B_CNT_LO = 32;
  localparam int unsigned B_IDX_LO = 16;
  localparam int unsigned B_USE_LO = 8;
  localparam int unsigned B_CHG_LO = 0;
endpackage

// File: rtl/vsr_imm_sat.sv
module vsr_imm_sat #(
  parameter int unsigned SECT     = 128,
  parameter bit          IDX_MODE = 1'b0
) (
  input  logic [31:0] imm_i,
  input  logic [15:0] ref_i,
  output logic [15:0] val_o,
  output logic [1:0]  cc_o
);
  localparam logic signed [31:0] SECT_S = 32'(SECT);

  logic signed [31:0] v;
  logic signed [31:0] ref_s;
  logic is_zero, is_neg, over, mid_hit;

  assign v       = $signed(imm_i);
  assign ref_s   = $signed({16'd0, ref_i});
  assign is_zero = (v == 32'sd0);
  assign is_neg  = v[31];
  assign over    = v > SECT_S;

  generate
    if (IDX_MODE) begin : g_idx
      assign mid_hit = v < ref_s;
    end else begin : g_cnt
      assign mid_hit = v > ref_s;
    end
  endgenerate

  always_comb begin
    if (is_zero)      cc_o = 2'd0;
    else if (is_neg)  cc_o = 2'd1;
    else if (mid_hit) cc_o = 2'd2;
    else              cc_o = 2'd3;
  end

  always_comb begin
    if (is_neg)    val_o = '0;
    else if (over) val_o = 16'(SECT);
    else           val_o = v[15:0];
  end
endmodule

// File: rtl/vsr_restore_chk.sv
module vsr_restore_chk
  import vsr_pkg::*;
#(
  parameter int unsigned SECT = 128
) (
  input  logic [W_WORD-1:0] opnd_i,
  input  logic              prob_i,
  input  logic [N_PAIR-1:0] cur_use_i,
  output logic              err_o,
  output logic [W_WORD-1:0] word_o,
  output logic [N_PAIR-1:0] drop_o
);
  localparam logic [W_FLD-1:0] SECT_F = W_FLD'(SECT);

  logic [W_FLD-1:0]  cnt, idx;
  logic [N_PAIR-1:0] use_new;

  assign cnt     = opnd_i[B_CNT_LO +: W_FLD];
  assign idx     = opnd_i[B_IDX_LO +: W_FLD];
  assign use_new = opnd_i[B_USE_LO +: N_PAIR];

  assign err_o = (|opnd_i[B_RES_HI:B_RES_LO]) || (cnt > SECT_F) || (idx >= SECT_F);

  always_comb begin
    word_o = opnd_i;
    if (prob_i) word_o[B_CHG_LO +: N_PAIR] = use_new;
  end

  assign drop_o = cur_use_i & ~use_new;
endmodule

// File: rtl/vsr_ctrl.sv
module vsr_ctrl
  import vsr_pkg::*;
#(
  parameter int unsigned SECT = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [2:0]  cmd_op_i,
  input  logic [63:0] cmd_opnd_i,
  input  logic        prob_state_i,
  output logic [15:0] vct_o,
  output logic [15:0] vix_o,
  output logic        mask_mode_o,
  output logic [15:0] mode_o,
  output logic [7:0]  inuse_o,
  output logic [7:0]  changed_o,
  output logic [7:0]  clr_req_o,
  output logic [1:0]  cc_o,
  output logic        cc_valid_o,
  output logic        spec_err_o
);
  logic [W_WORD-1:0] vsr_q;
  logic [N_PAIR-1:0] clr_q;
  logic [1:0]        cc_q;
  logic              cc_vld_q, err_q;

  logic [15:0]       cnt_val, idx_val;
  logic [1:0]        cnt_cc, idx_cc;
  logic              rst_err;
  logic [W_WORD-1:0] rst_word;
  logic [N_PAIR-1:0] rst_drop;

  vsr_imm_sat #(.SECT(SECT), .IDX_MODE(1'b0)) u_cnt (
    .imm_i (cmd_opnd_i[31:0]),
    .ref_i (16'(SECT)),
    .val_o (cnt_val),
    .cc_o  (cnt_cc)
  );

  vsr_imm_sat #(.SECT(SECT), .IDX_MODE(1'b1)) u_idx (
    .imm_i (cmd_opnd_i[31:0]),
    .ref_i (vsr_q[B_CNT_LO +: W_FLD]),
    .val_o (idx_val),
    .cc_o  (idx_cc)
  );

  vsr_restore_chk #(.SECT(SECT)) u_rst (
    .opnd_i    (cmd_opnd_i),
    .prob_i    (prob_state_i),
    .cur_use_i (vsr_q[B_USE_LO +: N_PAIR]),
    .err_o     (rst_err),
    .word_o    (rst_word),
    .drop_o    (rst_drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsr_q    <= '0;
      clr_q    <= '0;
      cc_q     <= '0;
      cc_vld_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      clr_q    <= '0;
      cc_vld_q <= 1'b0;
      err_q    <= 1'b0;
      if (cmd_valid_i) begin
        case (cmd_op_i)
          OP_LDCNT: begin
            vsr_q[B_CNT_LO +: W_FLD] <= cnt_val;
            cc_q     <= cnt_cc;
            cc_vld_q <= 1'b1;
          end
          OP_LDIDX: begin
            vsr_q[B_IDX_LO +: W_FLD] <= idx_val;
            cc_q     <= idx_cc;
            cc_vld_q <= 1'b1;
          end
          OP_MASK: vsr_q[B_MASK] <= cmd_opnd_i[0];
          OP_CLR: begin
            vsr_q[B_IDX_LO +: W_FLD]  <= '0;
            vsr_q[B_USE_LO +: N_PAIR] <= vsr_q[B_USE_LO +: N_PAIR] & ~cmd_opnd_i[N_PAIR-1:0];
            clr_q <= cmd_opnd_i[N_PAIR-1:0];
          end
          OP_RST: begin
            if (rst_err) begin
              err_q <= 1'b1;
            end else begin
              vsr_q <= rst_word;
              clr_q <= rst_drop;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign vct_o       = vsr_q[B_CNT_LO +: W_FLD];
  assign vix_o       = vsr_q[B_IDX_LO +: W_FLD];
  assign mask_mode_o = vsr_q[B_MASK];
  assign mode_o      = vsr_q[W_WORD-1 -: W_FLD];
  assign inuse_o     = vsr_q[B_USE_LO +: N_PAIR];
  assign changed_o   = vsr_q[B_CHG_LO +: N_PAIR];
  assign clr_req_o   = clr_q;
  assign cc_o        = cc_q;
  assign cc_valid_o  = cc_vld_q;
  assign spec_err_o  = err_q;
endmodule

// File: rtl/vsr_ctrl_chk.sv
module vsr_ctrl_chk #(
  parameter int unsigned SECT = 128
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] vct_o,
  input logic [15:0] vix_o,
  input logic        mask_mode_o,
  input logic [15:0] mode_o,
  input logic [7:0]  inuse_o,
  input logic [7:0]  changed_o,
  input logic [7:0]  clr_req_o,
  input logic        spec_err_o
);
  a_r2_vct_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vct_o <= 16'(SECT));

  a_r3_vix_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vix_o <= 16'(SECT));

  a_r4_mask_in_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_mode_o == mode_o[15]);

  a_r7_err_keeps_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_err_o |-> $stable({mode_o, vct_o, vix_o, inuse_o, changed_o}));

  a_r7_err_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_err_o |-> (clr_req_o == 8'h00));

  a_r9_cleared_not_inuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req_o != 8'h00) |-> ((clr_req_o & inuse_o) == 8'h00));
endmodule

bind vsr_ctrl vsr_ctrl_chk #(.SECT(SECT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vct_o       (vct_o),
  .vix_o       (vix_o),
  .mask_mode_o (mask_mode_o),
  .mode_o      (mode_o),
  .inuse_o     (inuse_o),
  .changed_o   (changed_o),
  .clr_req_o   (clr_req_o),
  .spec_err_o  (spec_err_o)
);

// File: tb/tb_vsr_ctrl.sv
module tb_vsr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] opnd = '0;
  logic        prob = 1'b0;
  logic [15:0] vct, vix, mode;
  logic        mask;
  logic [7:0]  inuse, chg, clr;
  logic [1:0]  cc;
  logic        ccv, err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vsr_ctrl #(.SECT(128)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(vld), .cmd_op_i(op),
    .cmd_opnd_i(opnd), .prob_state_i(prob), .vct_o(vct), .vix_o(vix),
    .mask_mode_o(mask), .mode_o(mode), .inuse_o(inuse), .changed_o(chg),
    .clr_req_o(clr), .cc_o(cc), .cc_valid_o(ccv), .spec_err_o(err)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic        prob;
    logic [63:0] opnd;
    logic        ccv;
    logic [1:0]  cc;
    logic [63:0] word;
    logic [7:0]  clr;
    logic        err;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  3'd0, 1'b0, 64'h0000_0000_0000_0005, 1'b1, 2'd3, 64'h0000_0005_0000_0000, 8'h00, 1'b0}, // R2
    '{4'd2,  3'd0, 1'b0, 64'h0000_0000_0000_0000, 1'b1, 2'd0, 64'h0000_0000_0000_0000, 8'h00, 1'b0}, // R2
    '{4'd2,  3'd0, 1'b0, 64'h0000_0000_FFFF_FFFF, 1'b1, 2'd1, 64'h0000_0000_0000_0000, 8'h00, 1'b0}, // R2
    '{4'd2,  3'd0, 1'b0, 64'h0000_0000_0000_00C8, 1'b1, 2'd2, 64'h0000_0080_0000_0000, 8'h00, 1'b0}, // R2
    '{4'd2,  3'd0, 1'b0, 64'h0000_0000_0000_0080, 1'b1, 2'd3, 64'h0000_0080_0000_0000, 8'h00, 1'b0}, // R2
    '{4'd3,  3'd1, 1'b0, 64'h0000_0000_0000_000A, 1'b1, 2'd2, 64'h0000_0080_000A_0000, 8'h00, 1'b0}, // R3
    '{4'd3,  3'd1, 1'b0, 64'h0000_0000_8000_0000, 1'b1, 2'd1, 64'h0000_0080_0000_0000, 8'h00, 1'b0}, // R3
    '{4'd3,  3'd1, 1'b0, 64'h0000_0000_0000_012C, 1'b1, 2'd3, 64'h0000_0080_0080_0000, 8'h00, 1'b0}, // R3
    '{4'd3,  3'd1, 1'b0, 64'h0000_0000_0000_0000, 1'b1, 2'd0, 64'h0000_0080_0000_0000, 8'h00, 1'b0}, // R3
    '{4'd4,  3'd2, 1'b0, 64'h0000_0000_0000_0003, 1'b0, 2'd0, 64'h8000_0080_0000_0000, 8'h00, 1'b0}, // R4
    '{4'd6,  3'd4, 1'b0, 64'h0000_0020_0005_F0A0, 1'b0, 2'd0, 64'h0000_0020_0005_F0A0, 8'h00, 1'b0}, // R6
    '{4'd8,  3'd4, 1'b1, 64'h8000_0010_0003_3055, 1'b0, 2'd0, 64'h8000_0010_0003_3030, 8'hC0, 1'b0}, // R8 R9
    '{4'd7,  3'd4, 1'b0, 64'h0001_0000_0000_0000, 1'b0, 2'd0, 64'h8000_0010_0003_3030, 8'h00, 1'b1}, // R7
    '{4'd7,  3'd4, 1'b0, 64'h0000_0081_0000_0000, 1'b0, 2'd0, 64'h8000_0010_0003_3030, 8'h00, 1'b1}, // R7
    '{4'd7,  3'd4, 1'b0, 64'h0000_0000_0080_0000, 1'b0, 2'd0, 64'h8000_0010_0003_3030, 8'h00, 1'b1}, // R7
    '{4'd6,  3'd4, 1'b0, 64'h0000_0080_007F_FF00, 1'b0, 2'd0, 64'h0000_0080_007F_FF00, 8'h00, 1'b0}, // R6
    '{4'd5,  3'd3, 1'b0, 64'h0000_0000_0000_0081, 1'b0, 2'd0, 64'h0000_0080_0000_7E00, 8'h81, 1'b0}, // R5
    '{4'd10, 3'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd0, 64'h0000_0080_0000_7E00, 8'h00, 1'b0}, // R10
    '{4'd3,  3'd1, 1'b0, 64'h0000_0000_0000_007F, 1'b1, 2'd2, 64'h0000_0080_007F_7E00, 8'h00, 1'b0}, // R3
    '{4'd3,  3'd1, 1'b0, 64'h0000_0000_0000_0080, 1'b1, 2'd3, 64'h0000_0080_0080_7E00, 8'h00, 1'b0}, // R3
    '{4'd9,  3'd4, 1'b1, 64'h0000_0000_0000_00FF, 1'b0, 2'd0, 64'h0000_0000_0000_0000, 8'h7E, 1'b0}, // R9 R8
    '{4'd6,  3'd4, 1'b0, 64'h0000_0000_0000_00FF, 1'b0, 2'd0, 64'h0000_0000_0000_00FF, 8'h00, 1'b0}  // R6
  };

  function automatic logic [63:0] word_now();
    return {mode, vct, vix, inuse, chg};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle_check(input string req, input logic [63:0] w);
    chk(req, word_now(), w);
    chk(req, {55'd0, clr, err}, 64'd0);
    chk(req, {63'd0, ccv}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    idle_check("R1", 64'd0);
    chk("R1", {62'd0, cc}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vld = 1'b1; op = VEC[i].op; opnd = VEC[i].opnd; prob = VEC[i].prob;
      @(negedge clk);
      chk($sformatf("R%0d word row %0d", VEC[i].req, i), word_now(), VEC[i].word);
      chk($sformatf("R%0d clr row %0d", VEC[i].req, i), {56'd0, clr}, {56'd0, VEC[i].clr});
      chk($sformatf("R%0d err row %0d", VEC[i].req, i), {63'd0, err}, {63'd0, VEC[i].err});
      chk($sformatf("R%0d ccv row %0d", VEC[i].req, i), {63'd0, ccv}, {63'd0, VEC[i].ccv});
      if (VEC[i].ccv) chk($sformatf("R%0d cc row %0d", VEC[i].req, i), {62'd0, cc}, {62'd0, VEC[i].cc});
      chk("R4 mask port", {63'd0, mask}, {63'd0, VEC[i].word[63]});
    end

    // R10: strobe low ignores a valid-looking command
    vld = 1'b0; op = 3'd0; opnd = 64'd5;
    @(negedge clk);
    idle_check("R10", 64'h0000_0000_0000_00FF);

    // R5 and R9: clear pulse lasts one cycle
    vld = 1'b1; op = 3'd4; prob = 1'b0; opnd = 64'h0000_0040_0010_C000;
    @(negedge clk);
    vld = 1'b1; op = 3'd3; opnd = 64'h0000_0000_0000_0040;
    @(negedge clk);
    chk("R5 clr", {56'd0, clr}, 64'h40);
    chk("R5 word", word_now(), 64'h0000_0040_0000_8000);
    vld = 1'b0;
    @(negedge clk);
    idle_check("R5 pulse end", 64'h0000_0040_0000_8000);

    // R7: rejected restore over live flags, then pulse ends
    vld = 1'b1; op = 3'd4; opnd = 64'h4000_0000_0000_0000;
    @(negedge clk);
    chk("R7 err", {63'd0, err}, 64'd1);
    chk("R7 clr", {56'd0, clr}, 64'd0);
    chk("R7 word", word_now(), 64'h0000_0040_0000_8000);
    vld = 1'b0;
    @(negedge clk);
    idle_check("R7 pulse end", 64'h0000_0040_0000_8000);

    // R1: asynchronous reset between edges
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 idle_check("R1 async", 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule